// File: doc/BRIEF.md
# Linked-list descriptor DMA engine

This block is a single-channel DMA engine. It moves 32-bit words between system memory and one peripheral register. Software writes one 64-bit order word. That word carries the start and stop command bits together with the address of the first descriptor in memory. The engine then reads the descriptor and moves the data the descriptor describes. When the descriptor is finished, the engine marks it done in memory and can raise an interrupt. It then follows the descriptor's next pointer for as long as that pointer is flagged valid. If the last descriptor points back to the first one, the engine cycles through the ring without end.

Each descriptor describes a number of blocks, each of a fixed number of words, with a programmable byte gap between consecutive memory blocks. The peripheral paces the transfer: it raises a request line before each block. A stop command pauses the engine at the next access boundary. A later start resumes it from the point where it stopped. An error response from memory ends the run and is reported.

Top module: `lldma_engine`

## Requirements
- R1: After reset, busy, err and irq are 0 and neither mem_req nor dev_req is asserted; while busy is 0 no request is issued on either port.
- R2: Writing the order word with bit 3 (start) set and bit 4 (stop) clear while idle starts a fetch. The descriptor address is the order word with bits 4:0 forced to zero. The engine reads the first ten descriptor words at that address plus 0, 4, 8 and so on up to 36. Word offsets: 0 next-low, 4 memory-low, 8 device address, 12 length in words, 16 gap in bytes, 20 block count, 24 command, 28 status, 32 next-high, 36 memory-high.
- R3: Command bit 12 selects the direction. When it is 1, each word is read from memory and then written to the device address. When it is 0, each word is read from the device address and then written to memory. Words move in ascending memory order.
- R4: A descriptor moves (block count) blocks of (length) words each. The memory address rises by 4 per word. After each block it rises by a further (gap) bytes, and the words in the gap are left untouched.
- R5: When a descriptor finishes, the engine writes the value 1 to its status word (offset 28) before it reads any further descriptor. The engine then pulses irq high for exactly one cycle if command bit 1 is set, and leaves irq low if that bit is clear.
- R6: If next-low bit 0 is 1, the engine goes on to fetch the descriptor at the next address, whose bit 0 is taken as 0. If next-low bit 0 is 0, the engine returns to idle with busy low.
- R7: A ring of descriptors whose next pointers all have bit 0 set runs without end and gives one irq pulse per completed descriptor.
- R8: An order write with bit 4 set halts the engine once the access in flight completes. No further access is issued and busy stays 1. A later write with bit 3 set resumes from the same word, ignores the address bits and does not fetch the descriptor again.
- R9: Order bit 0, captured at start, selects 64-bit addressing. When it is set, the upper 32 address bits come from the order word for the first descriptor, from next-high for later descriptors, and from memory-high for data. When it is clear, all upper address bits are 0.
- R10: A memory response with mem_rerr set aborts the run. The engine goes idle, sets err, pulses irq whatever command bit 1 says, and does not write the status word. The next start clears err.
- R11: Each block begins only while per_req is 1 and the engine is not halted. While the engine is idle, per_req has no effect.
- R12: A descriptor with length 0 or block count 0 moves no data but is still marked done and still raises its interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ord_we | input | 1 | Order word write strobe |
| ord_wdata | input | 64 | Order word: descriptor address and command bits |
| per_req | input | 1 | Peripheral ready for the next block |
| mem_req | output | 1 | Memory access request, held until mem_rvalid |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rvalid | input | 1 | Memory response for the held request |
| mem_rdata | input | 32 | Memory read data |
| mem_rerr | input | 1 | Memory response carries an error |
| dev_req | output | 1 | Device access request, held until dev_ack |
| dev_we | output | 1 | Device access is a write |
| dev_addr | output | 32 | Device register address |
| dev_wdata | output | 32 | Device write data |
| dev_ack | input | 1 | Device access complete |
| dev_rdata | input | 32 | Device read data |
| irq | output | 1 | One-cycle interrupt pulse |
| busy | output | 1 | Engine is running or halted mid-chain |
| err | output | 1 | Last run ended on a memory error |

## Verification
The hardest situation to reach from the ports is a halt in the middle of a block followed by a resume. The stop must land while an access is in flight, and the resume must not fetch the descriptor again. The bench watches the device write count and issues stop once a few words have moved. It then checks that both ports stay quiet, and resumes with a different address in the order word. Afterwards it checks the full data stream and that the descriptor was read only once. The ring case is reached by linking two descriptors to each other and counting interrupt pulses while the engine keeps running.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
  localparam int WORD_W      = 32;
  localparam int ADDR_W      = 2 * WORD_W;
  localparam int WORD_BYTES  = WORD_W / 8;
  localparam int FETCH_WORDS = 10;
  localparam int STAT_IDX    = 7;
  localparam int NEXT_OK_BIT = 0;
  localparam int IRQ_EN_BIT  = 1;
  localparam int DIR_BIT     = 12;
  localparam int ORD_WIDE_BIT = 0;
  localparam int ORD_GO_BIT   = 3;
  localparam int ORD_HALT_BIT = 4;
  localparam int ORD_ALIGN    = 5;
  localparam logic [WORD_W-1:0] DONE_MARK = WORD_W'(1);

  // word i of a fetched descriptor lands at bits [i*WORD_W +: WORD_W]
  typedef struct packed {
    logic [WORD_W-1:0] mem_hi;
    logic [WORD_W-1:0] nxt_hi;
    logic [WORD_W-1:0] stat;
    logic [WORD_W-1:0] cmd;
    logic [WORD_W-1:0] times;
    logic [WORD_W-1:0] step;
    logic [WORD_W-1:0] len;
    logic [WORD_W-1:0] dev_a;
    logic [WORD_W-1:0] mem_lo;
    logic [WORD_W-1:0] nxt_lo;
  } desc_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_WAITP, S_SRC, S_DST, S_STAT
  } seq_state_t;

  function automatic logic [ADDR_W-1:0] join_addr(input logic wide,
                                                  input logic [WORD_W-1:0] hi,
                                                  input logic [WORD_W-1:0] lo);
    return wide ? {hi, lo} : {{(ADDR_W-WORD_W){1'b0}}, lo};
  endfunction

  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [7:0] idx);
    return base + ADDR_W'(idx) * ADDR_W'(WORD_BYTES);
  endfunction

  // address of the first word of the following block
  function automatic logic [ADDR_W-1:0] next_block(input logic [ADDR_W-1:0] last_ptr,
                                                   input logic [WORD_W-1:0] gap);
    return last_ptr + ADDR_W'(WORD_BYTES) + ADDR_W'(gap);
  endfunction
endpackage

// File: rtl/lldma_order.sv
module lldma_order
  import lldma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ord_we,
  input  logic [ADDR_W-1:0] ord_wdata,
  input  logic              busy,
  output logic              go_new,
  output logic [ADDR_W-1:0] first_desc,
  output logic              halted,
  output logic              wide
);
  logic go_bit, halt_bit;
  logic unused_ord;

  assign go_bit     = ord_wdata[ORD_GO_BIT];
  assign halt_bit   = ord_wdata[ORD_HALT_BIT];
  assign go_new     = ord_we && go_bit && !halt_bit && !busy;
  assign first_desc = join_addr(ord_wdata[ORD_WIDE_BIT], ord_wdata[ADDR_W-1:WORD_W],
                                {ord_wdata[WORD_W-1:ORD_ALIGN], {ORD_ALIGN{1'b0}}});
  assign unused_ord = ^ord_wdata[ORD_GO_BIT-1:ORD_WIDE_BIT+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted <= 1'b0;
      wide   <= 1'b0;
    end else begin
      if (ord_we && halt_bit)    halted <= 1'b1;
      else if (ord_we && go_bit) halted <= 1'b0;
      if (go_new) wide <= ord_wdata[ORD_WIDE_BIT];
    end
  end

  a_r8_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
    ord_we && halt_bit |=> halted);
  a_r8_go_releases: assert property (@(posedge clk) disable iff (!rst_n)
    ord_we && go_bit && !halt_bit |=> !halted);
endmodule

// File: rtl/lldma_desc_regs.sv
module lldma_desc_regs
  import lldma_pkg::*;
#(
  parameter int NWORDS = FETCH_WORDS,
  localparam int IDX_W = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [IDX_W-1:0]  cap_idx,
  input  logic [WORD_W-1:0] cap_data,
  output desc_t             desc
);
  logic [WORD_W-1:0]        words [NWORDS];
  logic [NWORDS*WORD_W-1:0] flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) words[i] <= '0;
    end else if (cap_en) begin
      for (int i = 0; i < NWORDS; i++)
        if (cap_idx == IDX_W'(i)) words[i] <= cap_data;
    end
  end

  for (genvar g = 0; g < NWORDS; g++) begin : g_pack
    assign flat[g*WORD_W +: WORD_W] = words[g];
  end

  assign desc = desc_t'(flat);
endmodule

// File: rtl/lldma_seq.sv
module lldma_seq
  import lldma_pkg::*;
#(
  parameter int CNT_W = WORD_W,
  localparam int IDX_W = $clog2(FETCH_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_new,
  input  logic [ADDR_W-1:0] first_desc,
  input  logic              halted,
  input  logic              wide,
  input  desc_t             desc,
  output logic              cap_en,
  output logic [IDX_W-1:0]  cap_idx,
  input  logic              per_req,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_rerr,
  output logic              dev_req,
  output logic              dev_we,
  output logic [WORD_W-1:0] dev_addr,
  output logic [WORD_W-1:0] dev_wdata,
  input  logic              dev_ack,
  input  logic [WORD_W-1:0] dev_rdata,
  output logic              irq,
  output logic              busy,
  output logic              err
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FETCH_WORDS - 1);

  seq_state_t        state;
  logic [IDX_W-1:0]  fidx;
  logic [CNT_W-1:0]  wcnt, bcnt;
  logic [ADDR_W-1:0] mptr, cur_desc;
  logic [WORD_W-1:0] data_q;
  logic req_m, req_d, irq_q, err_q;

  // named events used by the sequencer and the assertions
  logic to_dev, need_mem, need_dev, mem_done, mem_fail, mem_ok, dev_ok;
  logic last_word, last_block, empty_desc, unused_desc;

  assign to_dev     = desc.cmd[DIR_BIT];
  assign need_mem   = (state == S_FETCH) || (state == S_STAT) ||
                      (state == S_SRC && to_dev) || (state == S_DST && !to_dev);
  assign need_dev   = (state == S_SRC && !to_dev) || (state == S_DST && to_dev);
  assign mem_done   = req_m && mem_rvalid;
  assign mem_fail   = mem_done && mem_rerr;
  assign mem_ok     = mem_done && !mem_rerr;
  assign dev_ok     = req_d && dev_ack;
  assign last_word  = (wcnt == desc.len - 1'b1);
  assign last_block = (bcnt == desc.times - 1'b1);
  assign empty_desc = (desc.len == '0) || (desc.times == '0);
  assign unused_desc = ^desc.stat;

  assign cap_en  = mem_ok && (state == S_FETCH);
  assign cap_idx = fidx;

  always_comb begin
    mem_addr  = mptr;
    mem_we    = 1'b0;
    mem_wdata = data_q;
    case (state)
      S_FETCH: mem_addr = word_addr(cur_desc, 8'(fidx));
      S_STAT: begin
        mem_addr  = word_addr(cur_desc, 8'(STAT_IDX));
        mem_we    = 1'b1;
        mem_wdata = DONE_MARK;
      end
      S_DST:   mem_we = !to_dev;
      default: ;
    endcase
  end

  assign mem_req   = req_m;
  assign dev_req   = req_d;
  assign dev_we    = (state == S_DST);
  assign dev_addr  = desc.dev_a;
  assign dev_wdata = data_q;
  assign irq       = irq_q;
  assign err       = err_q;
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; fidx <= '0; wcnt <= '0; bcnt <= '0;
      mptr <= '0; cur_desc <= '0; data_q <= '0;
      req_m <= 1'b0; req_d <= 1'b0; irq_q <= 1'b0; err_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (mem_done)                          req_m <= 1'b0;
      else if (!req_m && need_mem && !halted) req_m <= 1'b1;
      if (dev_ok)                            req_d <= 1'b0;
      else if (!req_d && need_dev && !halted) req_d <= 1'b1;

      if (mem_fail) begin
        state <= S_IDLE;
        err_q <= 1'b1;
        irq_q <= 1'b1;
      end else begin
        case (state)
          S_IDLE: if (go_new) begin
            cur_desc <= first_desc;
            fidx     <= '0;
            err_q    <= 1'b0;
            state    <= S_FETCH;
          end
          S_FETCH: if (mem_ok) begin
            fidx <= fidx + 1'b1;
            if (fidx == LAST_IDX) state <= S_CHECK;
          end
          S_CHECK: begin
            mptr  <= join_addr(wide, desc.mem_hi, desc.mem_lo);
            wcnt  <= '0;
            bcnt  <= '0;
            state <= empty_desc ? S_STAT : S_WAITP;
          end
          S_WAITP: if (per_req && !halted) state <= S_SRC;
          S_SRC: if (mem_ok || dev_ok) begin
            data_q <= to_dev ? mem_rdata : dev_rdata;
            state  <= S_DST;
          end
          S_DST: if (mem_ok || dev_ok) begin
            if (last_word) begin
              wcnt  <= '0;
              bcnt  <= bcnt + 1'b1;
              mptr  <= next_block(mptr, desc.step);
              state <= last_block ? S_STAT : S_WAITP;
            end else begin
              wcnt  <= wcnt + 1'b1;
              mptr  <= mptr + ADDR_W'(WORD_BYTES);
              state <= S_SRC;
            end
          end
          S_STAT: if (mem_ok) begin
            irq_q <= desc.cmd[IRQ_EN_BIT];
            if (desc.nxt_lo[NEXT_OK_BIT]) begin
              cur_desc <= join_addr(wide, desc.nxt_hi, {desc.nxt_lo[WORD_W-1:1], 1'b0});
              fidx     <= '0;
              state    <= S_FETCH;
            end else begin
              state <= S_IDLE;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  a_r5_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  a_r3_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_m && req_d));
  a_r8_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_m && !mem_rvalid |=> req_m && $stable(mem_addr) && $stable(mem_we));
  a_r10_fault_ends: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fail |=> (state == S_IDLE) && err_q && irq_q);
  a_r11_wait_peripheral: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAITP) && !per_req |=> (state == S_WAITP));
  a_r5_done_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STAT) && mem_ok && desc.nxt_lo[NEXT_OK_BIT] |=> (state == S_FETCH) && (fidx == '0));
endmodule

// File: rtl/lldma_engine.sv
module lldma_engine
  import lldma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ord_we,
  input  logic [ADDR_W-1:0] ord_wdata,
  input  logic              per_req,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_rerr,
  output logic              dev_req,
  output logic              dev_we,
  output logic [WORD_W-1:0] dev_addr,
  output logic [WORD_W-1:0] dev_wdata,
  input  logic              dev_ack,
  input  logic [WORD_W-1:0] dev_rdata,
  output logic              irq,
  output logic              busy,
  output logic              err
);
  localparam int IDX_W = $clog2(FETCH_WORDS);

  logic              go_new, halted, wide, cap_en;
  logic [ADDR_W-1:0] first_desc;
  logic [IDX_W-1:0]  cap_idx;
  desc_t             desc;

  lldma_order u_order (
    .clk(clk), .rst_n(rst_n), .ord_we(ord_we), .ord_wdata(ord_wdata), .busy(busy),
    .go_new(go_new), .first_desc(first_desc), .halted(halted), .wide(wide)
  );

  lldma_desc_regs #(.NWORDS(FETCH_WORDS)) u_desc (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_idx(cap_idx),
    .cap_data(mem_rdata), .desc(desc)
  );

  lldma_seq #(.CNT_W(WORD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .go_new(go_new), .first_desc(first_desc),
    .halted(halted), .wide(wide), .desc(desc), .cap_en(cap_en), .cap_idx(cap_idx),
    .per_req(per_req),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
    .dev_req(dev_req), .dev_we(dev_we), .dev_addr(dev_addr), .dev_wdata(dev_wdata),
    .dev_ack(dev_ack), .dev_rdata(dev_rdata),
    .irq(irq), .busy(busy), .err(err)
  );

  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !dev_req);
endmodule

// File: tb/lldma_engine_tb.sv
module lldma_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DESC_A   = 32'h100;
  localparam logic [31:0] DESC_B   = 32'h200;
  localparam logic [31:0] BUF      = 32'h400;
  localparam logic [31:0] DEV_ADDR = 32'h0000_0F00;
  // vector: {dir, ien, len[7:0], times[7:0], gap[7:0]}
  localparam int NVEC = 6;
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 8'd3, 8'd1, 8'd0},
    {1'b1, 1'b1, 8'd2, 8'd3, 8'd8},
    {1'b0, 1'b0, 8'd4, 8'd2, 8'd4},
    {1'b0, 1'b1, 8'd1, 8'd3, 8'd12},
    {1'b1, 1'b1, 8'd0, 8'd2, 8'd0},
    {1'b0, 1'b1, 8'd2, 8'd0, 8'd0}
  };

  logic clk = 0, rst_n = 0;
  logic ord_we = 0;
  logic [63:0] ord_wdata = '0;
  logic per_req = 0;
  logic mem_req, mem_we, mem_rvalid, mem_rerr;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic dev_req, dev_we, dev_ack;
  logic [31:0] dev_addr, dev_wdata, dev_rdata;
  logic irq, busy, err;

  int checks = 0, errors = 0;
  logic [31:0] mem [1024];
  logic [31:0] dev_log [64];
  int dev_wr_n, dev_rd_n, irq_n, hi_bad, dev_addr_bad, fetch_a_n;
  logic [31:0] exp_hi, err_addr, a_stat_at_b;
  bit err_armed, b_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  lldma_engine u_dut (
    .clk(clk), .rst_n(rst_n), .ord_we(ord_we), .ord_wdata(ord_wdata), .per_req(per_req),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
    .dev_req(dev_req), .dev_we(dev_we), .dev_addr(dev_addr), .dev_wdata(dev_wdata),
    .dev_ack(dev_ack), .dev_rdata(dev_rdata), .irq(irq), .busy(busy), .err(err)
  );

  // memory model: answers a held request at the following negedge
  initial begin
    mem_rvalid = 0; mem_rdata = '0; mem_rerr = 0;
    forever begin
      @(negedge clk);
      if (mem_rvalid) begin
        mem_rvalid = 0; mem_rerr = 0;
      end else if (mem_req) begin
        if (mem_addr[63:32] != exp_hi) hi_bad++;
        if (!mem_we && mem_addr[31:0] == DESC_A) fetch_a_n++;
        if (!mem_we && mem_addr[31:0] == DESC_B && !b_seen) begin
          b_seen = 1; a_stat_at_b = mem[DESC_A[11:2] + 7];
        end
        mem_rerr = err_armed && (mem_addr[31:0] == err_addr);
        if (mem_we && !mem_rerr) mem[mem_addr[11:2]] = mem_wdata;
        else mem_rdata = mem[mem_addr[11:2]];
        mem_rvalid = 1;
      end
    end
  end

  // device model: reads return a running tag, writes are logged
  initial begin
    dev_ack = 0; dev_rdata = '0;
    forever begin
      @(negedge clk);
      if (dev_ack) dev_ack = 0;
      else if (dev_req) begin
        if (dev_addr != DEV_ADDR) dev_addr_bad++;
        if (dev_we) begin
          if (dev_wr_n < 64) dev_log[dev_wr_n] = dev_wdata;
          dev_wr_n++;
        end else begin
          dev_rdata = 32'hD000_0000 + 32'(dev_rd_n);
          dev_rd_n++;
        end
        dev_ack = 1;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (irq) irq_n++;
  end

  task automatic check_eq(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    dev_wr_n = 0; dev_rd_n = 0; irq_n = 0; hi_bad = 0; dev_addr_bad = 0;
    fetch_a_n = 0; b_seen = 0; a_stat_at_b = '0;
  endtask

  task automatic fill_buf();
    for (int i = 256; i < 512; i++) mem[i] = 32'h1000 + 32'(i);
  endtask

  task automatic put_desc(input logic [31:0] base, input logic [31:0] nxt_lo,
                          input logic [31:0] mem_lo, input logic [31:0] len,
                          input logic [31:0] gap, input logic [31:0] times,
                          input logic [31:0] cmd, input logic [31:0] nxt_hi,
                          input logic [31:0] mem_hi);
    int b;
    b = int'(base[11:2]);
    mem[b+0] = nxt_lo; mem[b+1] = mem_lo; mem[b+2] = DEV_ADDR; mem[b+3] = len;
    mem[b+4] = gap; mem[b+5] = times; mem[b+6] = cmd; mem[b+7] = '0;
    mem[b+8] = nxt_hi; mem[b+9] = mem_hi; mem[b+10] = '0; mem[b+11] = '0;
  endtask

  task automatic order(input logic [63:0] v);
    @(negedge clk); ord_we = 1; ord_wdata = v;
    @(negedge clk); ord_we = 0; ord_wdata = '0;
  endtask

  task automatic wait_idle(input int limit);
    for (int i = 0; i < limit && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int derr;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    exp_hi = '0; err_addr = '0; err_armed = 0;
    clear_logs();
    repeat (3) @(negedge clk);
    // R1 reset state
    check_eq("R1", "busy after reset", busy, 0);
    check_eq("R1", "irq/err after reset", {irq, err}, 0);
    check_eq("R1", "requests after reset", {mem_req, dev_req}, 0);
    rst_n = 1;
    // R11 per_req ignored while idle
    per_req = 1;
    repeat (40) @(negedge clk);
    check_eq("R11", "accesses while idle", dev_wr_n + dev_rd_n + hi_bad + fetch_a_n, 0);
    check_eq("R1", "busy while idle", busy, 0);

    // table walk: single descriptors, R2 R3 R4 R5 R12 and R9 with 32-bit mode
    for (int v = 0; v < NVEC; v++) begin
      logic dir, ien;
      int len, times, gap, k;
      {dir, ien} = VEC[v][25:24];
      len = int'(VEC[v][23:16]); times = int'(VEC[v][15:8]); gap = int'(VEC[v][7:0]);
      fill_buf();
      put_desc(DESC_A, 32'h0, BUF, 32'(len), 32'(gap), 32'(times),
               (32'(dir) << 12) | (32'(ien) << 1), 32'h0, 32'h55);
      clear_logs();
      order({32'h0, DESC_A} | 64'h8);
      wait_idle(2000);
      check_eq("R5", $sformatf("status word v%0d", v), mem[DESC_A[11:2] + 7], 1);
      check_eq("R5", $sformatf("irq count v%0d", v), irq_n, ien);
      check_eq("R2", $sformatf("descriptor fetched v%0d", v), fetch_a_n, 1);
      check_eq("R9", $sformatf("upper address zero v%0d", v), hi_bad, 0);
      check_eq("R4", $sformatf("word count v%0d", v), dir ? dev_wr_n : dev_rd_n, len * times);
      derr = 0; k = 0;
      for (int b = 0; b < times; b++)
        for (int w = 0; w < len; w++) begin
          int idx;
          idx = (int'(BUF) + b * (len * 4 + gap) + w * 4) / 4;
          if (dir) begin
            if (dev_log[k] != 32'h1000 + 32'(idx)) derr++;
          end else if (mem[idx] != 32'hD000_0000 + 32'(k)) derr++;
          k++;
        end
      check_eq(len * times == 0 ? "R12" : "R3", $sformatf("data mismatches v%0d", v), derr, 0);
      if (gap > 0 && times > 1)
        check_eq("R4", $sformatf("gap untouched v%0d", v),
                 mem[(int'(BUF) + len * 4) / 4], 32'h1000 + 32'((int'(BUF) + len * 4) / 4));
    end

    // R11 block waits for per_req
    per_req = 0;
    fill_buf();
    put_desc(DESC_A, 32'h0, BUF, 2, 0, 2, 32'h1002, 0, 0);
    clear_logs();
    order({32'h0, DESC_A} | 64'h8);
    repeat (60) @(negedge clk);
    check_eq("R11", "busy while peripheral silent", busy, 1);
    check_eq("R11", "no device writes without per_req", dev_wr_n, 0);
    per_req = 1;
    wait_idle(2000);
    check_eq("R11", "words after per_req", dev_wr_n, 4);
    check_eq("R6", "idle after end of chain", busy, 0);

    // R6 + R5 + R9: two-link chain in 64-bit mode
    fill_buf();
    put_desc(DESC_A, DESC_B | 32'h1, BUF, 2, 0, 1, 32'h1000, 32'hA, 32'hA);
    put_desc(DESC_B, 32'h0, BUF + 32'h40, 1, 0, 1, 32'h1002, 32'hA, 32'hA);
    clear_logs();
    exp_hi = 32'hA;
    order({32'hA, DESC_A} | 64'h9);
    wait_idle(3000);
    exp_hi = '0;
    check_eq("R6", "chain word count", dev_wr_n, 3);
    check_eq("R6", "second link data", dev_log[2], 32'h1000 + 32'((BUF + 32'h40) >> 2));
    check_eq("R5", "done before next fetch", a_stat_at_b, 1);
    check_eq("R5", "irq only from enabled link", irq_n, 1);
    check_eq("R9", "upper address bits used", hi_bad, 0);
    check_eq("R3", "device address", dev_addr_bad, 0);

    // R8 pause and resume
    fill_buf();
    put_desc(DESC_A, 32'h0, BUF, 8, 0, 2, 32'h1002, 0, 0);
    clear_logs();
    order({32'h0, DESC_A} | 64'h8);
    for (int i = 0; i < 2000 && dev_wr_n < 3; i++) @(negedge clk);
    order(64'h10);
    repeat (10) @(negedge clk);
    begin
      int snap;
      snap = dev_wr_n;
      repeat (40) @(negedge clk);
      check_eq("R8", "no progress while halted", dev_wr_n, snap);
      check_eq("R8", "ports quiet while halted", {mem_req, dev_req}, 0);
      check_eq("R8", "busy while halted", busy, 1);
    end
    order(64'h3E8);
    wait_idle(3000);
    check_eq("R8", "all words after resume", dev_wr_n, 16);
    derr = 0;
    for (int k = 0; k < 16; k++) if (dev_log[k] != 32'h1000 + 32'(256 + k)) derr++;
    check_eq("R8", "resumed data order", derr, 0);
    check_eq("R8", "no refetch on resume", fetch_a_n, 1);

    // R10 memory error
    fill_buf();
    put_desc(DESC_A, 32'h0, BUF, 2, 0, 1, 32'h1000, 0, 0);
    clear_logs();
    err_armed = 1; err_addr = BUF + 4;
    order({32'h0, DESC_A} | 64'h8);
    wait_idle(2000);
    err_armed = 0;
    check_eq("R10", "err flag", err, 1);
    check_eq("R10", "busy after error", busy, 0);
    check_eq("R10", "forced irq", irq_n, 1);
    check_eq("R10", "status not written", mem[DESC_A[11:2] + 7], 0);
    check_eq("R10", "words before error", dev_wr_n, 1);
    order({32'h0, DESC_A} | 64'h8);
    check_eq("R10", "err cleared by start", err, 0);
    wait_idle(2000);

    // R7 ring
    fill_buf();
    put_desc(DESC_A, DESC_B | 32'h1, BUF, 1, 0, 1, 32'h1002, 0, 0);
    put_desc(DESC_B, DESC_A | 32'h1, BUF + 32'h40, 1, 0, 1, 32'h1002, 0, 0);
    clear_logs();
    order({32'h0, DESC_A} | 64'h8);
    for (int i = 0; i < 3000 && irq_n < 5; i++) @(negedge clk);
    check_eq("R7", "ring irq count reached", irq_n >= 5, 1);
    check_eq("R7", "ring still busy", busy, 1);
    check_eq("R7", "ring marks both done", mem[DESC_A[11:2] + 7] + mem[DESC_B[11:2] + 7], 2);
    order(64'h10);
    repeat (10) @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    check_eq("R1", "busy after reset in ring", busy, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule